// File: doc/BRIEF.md
# USB Ping-Pong Descriptor Bank Controller

This block holds the control and status state that a USB device serial interface engine needs to steer double-buffered endpoints. For each endpoint that has two buffer descriptors, it keeps an even/odd bank bit. That bit flips after every completed transaction, so the next transaction uses the other descriptor. Endpoints that are not double-buffered always select the even bank.

When a transaction completes, the block records two facts about it: its direction, and which bank it used. A setup token raises a lock that stops the engine from accepting more tokens. Software lifts the lock after it has drained the descriptors.

A control register gives software four controls: the module enable, a one-shot command that returns every bank bit to even, the resume-signaling request for remote wakeup, and the token lock. Turning the enable on from off also returns every bank bit to even.

Top module: `usb_bank_ctl`

## Requirements
- R1: After reset, the control readback is 0x00. All bank selects, both status bits, the lock flag, the resume request and the token acknowledge are 0.
- R2: The control readback places the lock at bit 5, the resume request at bit 2, the bank-reset command at bit 1 and the enable at bit 0. The bank-reset command and bits 7, 6, 4 and 3 always read 0.
- R3: A completed transaction with the setup flag set, seen while the block is enabled, sets the lock on the next clock edge. This includes the case where the lock is already set.
- R4: The token acknowledge follows the token request only while the block is enabled and the lock is clear. Otherwise the acknowledge is 0.
- R5: A control write with bit 5 at 0 clears the lock, and writing 1 to bit 5 leaves the lock unchanged. If a setup transaction arrives in the same cycle as the clearing write, the lock stays set.
- R6: Each accepted transaction loads the direction status bit: 1 for a transmit (IN) transfer, 0 for a receive (OUT) transfer.
- R7: Each accepted transaction loads the bank status bit with the bank select its endpoint had when the transaction was accepted: 1 for odd, 0 for even.
- R8: The bank select of a double-buffered endpoint (5 and 6 by default) inverts after each accepted transaction on that endpoint. The bank select of any other endpoint stays 0.
- R9: A control write with bit 1 at 1 forces every bank select to 0. This takes priority over a toggle in the same cycle.
- R10: A control write that changes the enable bit from 0 to 1 forces every bank select to 0. A write that leaves the enable at 1, and a write that disables the block, keep the bank selects.
- R11: While the enable bit is 0, transaction strobes change no status bit, no bank select and not the lock.
- R12: The resume-signaling output equals the resume request bit of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register readback |
| xact_vld_i | input | 1 | Transaction-complete strobe |
| xact_ep_i | input | EP_W (4) | Endpoint number of the completed transaction |
| xact_in_i | input | 1 | Direction of the completed transaction: 1 for IN, 0 for OUT |
| xact_setup_i | input | 1 | Completed transaction was a setup token |
| tok_req_i | input | 1 | Token acceptance request from the engine |
| tok_ack_o | output | 1 | Token acceptance grant |
| bank_sel_o | output | NUM_EP (16) | Bank select per endpoint: 1 for odd, 0 for even |
| stat_in_o | output | 1 | Direction of the last accepted transaction |
| stat_odd_o | output | 1 | Bank used by the last accepted transaction |
| tsusp_o | output | 1 | Token-processing lock |
| resume_o | output | 1 | Resume-signaling request |

## Verification
The toggle is driven with alternating OUT and IN transactions on each double-buffered endpoint. This shows that each bank select flips on its own and that the bank status reports the bank used before the flip. Transactions on a single-buffered endpoint show that only the masked endpoints ever toggle.

Two priority cases are tested: a bank-reset write that coincides with a toggle, and a lock-clearing write that coincides with a setup token. These tell the priority order apart from the plain update. Enable writes are tried both as a 0-to-1 change and as a rewrite of 1. Strobes are also sent while the block is disabled. Together these separate the edge-triggered bank clear from a level-triggered one, and show that a disabled block gates every update.

// File: rtl/usb_bank_pkg.sv
package usb_bank_pkg;
  localparam int unsigned CTL_W        = 8;
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_ODD_BIT  = 1;
  localparam int unsigned CTL_RES_BIT  = 2;
  localparam int unsigned CTL_SUSP_BIT = 5;

  typedef struct packed {
    logic dir_in;
    logic bank_odd;
  } xact_stat_t;
endpackage

// File: rtl/usb_ctl_reg.sv
module usb_ctl_reg
  import usb_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             setup_i,
  output logic [CTL_W-1:0] rdata_o,
  output logic             usb_en_o,
  output logic             tsusp_o,
  output logic             resume_o,
  output logic             bank_clr_o
);
  logic en_q, susp_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      // hardware set wins over a software clear
      if (setup_i)                              susp_q <= 1'b1;
      else if (we_i && !wdata_i[CTL_SUSP_BIT])  susp_q <= 1'b0;
      if (we_i) begin
        en_q  <= wdata_i[CTL_EN_BIT];
        res_q <= wdata_i[CTL_RES_BIT];
      end
    end
  end

  // one-shot bank clear: explicit command or enable rising
  assign bank_clr_o = we_i & (wdata_i[CTL_ODD_BIT] | (wdata_i[CTL_EN_BIT] & ~en_q));

  always_comb begin
    rdata_o               = '0;
    rdata_o[CTL_EN_BIT]   = en_q;
    rdata_o[CTL_RES_BIT]  = res_q;
    rdata_o[CTL_SUSP_BIT] = susp_q;
  end

  assign usb_en_o = en_q;
  assign tsusp_o  = susp_q;
  assign resume_o = res_q;

  assert_setup_locks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> susp_q);
  assert_sw_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[CTL_SUSP_BIT] && !setup_i) |=> !susp_q);
  assert_no_sw_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!susp_q && !setup_i) |=> !susp_q);
endmodule

// File: rtl/usb_bank_toggle.sv
module usb_bank_toggle #(
  parameter int unsigned         NUM_EP   = 16,
  parameter logic [NUM_EP-1:0]   DBL_MASK = 16'h0060,
  localparam int unsigned        EP_W     = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [EP_W-1:0]   ep_i,
  input  logic              clr_i,
  output logic [NUM_EP-1:0] bank_o
);
  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    if (DBL_MASK[e]) begin : g_dbl
      logic bank_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 bank_q <= 1'b0;
        else if (clr_i)                              bank_q <= 1'b0;
        else if (upd_i && ep_i == EP_W'(e))          bank_q <= ~bank_q;
      end
      assign bank_o[e] = bank_q;

      assert_flip_on_use_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_i && ep_i == EP_W'(e) && !clr_i) |=> (bank_q != $past(bank_q)));
    end else begin : g_single
      assign bank_o[e] = 1'b0;
    end
  end

  assert_clr_even_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bank_o == '0));
endmodule

// File: rtl/usb_xact_status.sv
module usb_xact_status
  import usb_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       en_i,
  input  logic       dir_in_i,
  input  logic       bank_odd_i,
  output xact_stat_t stat_o
);
  xact_stat_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (upd_i) stat_q <= '{dir_in: dir_in_i, bank_odd: bank_odd_i};
  end

  assign stat_o = stat_q;

  assert_hold_when_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(stat_q));
  assert_dir_loaded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (stat_q.dir_in == $past(dir_in_i)));
endmodule

// File: rtl/usb_bank_ctl.sv
module usb_bank_ctl
  import usb_bank_pkg::*;
#(
  parameter int unsigned       NUM_EP   = 16,
  parameter logic [NUM_EP-1:0] DBL_MASK = 16'h0060,
  localparam int unsigned      EP_W     = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              xact_vld_i,
  input  logic [EP_W-1:0]   xact_ep_i,
  input  logic              xact_in_i,
  input  logic              xact_setup_i,
  input  logic              tok_req_i,
  output logic              tok_ack_o,
  output logic [NUM_EP-1:0] bank_sel_o,
  output logic              stat_in_o,
  output logic              stat_odd_o,
  output logic              tsusp_o,
  output logic              resume_o
);
  logic       usb_en, bank_clr, upd, setup_upd;
  xact_stat_t stat;

  assign upd       = xact_vld_i & usb_en;
  assign setup_upd = upd & xact_setup_i;

  usb_ctl_reg u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .setup_i    (setup_upd),
    .rdata_o    (reg_rdata_o),
    .usb_en_o   (usb_en),
    .tsusp_o    (tsusp_o),
    .resume_o   (resume_o),
    .bank_clr_o (bank_clr)
  );

  usb_bank_toggle #(.NUM_EP(NUM_EP), .DBL_MASK(DBL_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .ep_i   (xact_ep_i),
    .clr_i  (bank_clr),
    .bank_o (bank_sel_o)
  );

  usb_xact_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .en_i       (usb_en),
    .dir_in_i   (xact_in_i),
    .bank_odd_i (bank_sel_o[xact_ep_i]),
    .stat_o     (stat)
  );

  assign stat_in_o  = stat.dir_in;
  assign stat_odd_o = stat.bank_odd;
  assign tok_ack_o  = tok_req_i & usb_en & ~tsusp_o;

  assert_ack_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsusp_o || !reg_rdata_o[0]) |-> !tok_ack_o);
  assert_bank_reported_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (stat_odd_o == $past(bank_sel_o[xact_ep_i])));
  assert_resume_tracks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o == reg_rdata_o[2]);
endmodule

// File: tb/tb_usb_bank_ctl.sv
module tb_usb_bank_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        xact_vld = 1'b0;
  logic [3:0]  xact_ep = '0;
  logic        xact_in = 1'b0;
  logic        xact_setup = 1'b0;
  logic        tok_req = 1'b0;
  logic        tok_ack;
  logic [15:0] bank_sel;
  logic        stat_in, stat_odd, tsusp, resume;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_bank_ctl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xact_vld_i(xact_vld), .xact_ep_i(xact_ep), .xact_in_i(xact_in),
    .xact_setup_i(xact_setup), .tok_req_i(tok_req), .tok_ack_o(tok_ack),
    .bank_sel_o(bank_sel), .stat_in_o(stat_in), .stat_odd_o(stat_odd),
    .tsusp_o(tsusp), .resume_o(resume)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, release and return at next negedge
  task automatic cycle(input logic we, input logic [7:0] wd,
                       input logic vld, input logic [3:0] ep,
                       input logic in_dir, input logic setup);
    reg_we = we; reg_wdata = wd;
    xact_vld = vld; xact_ep = ep; xact_in = in_dir; xact_setup = setup;
    @(negedge clk);
    reg_we = 1'b0; xact_vld = 1'b0; xact_setup = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    cycle(1'b1, d, 1'b0, 4'd0, 1'b0, 1'b0);
  endtask

  task automatic xact(input logic [3:0] ep, input logic in_dir, input logic setup);
    cycle(1'b0, 8'h00, 1'b1, ep, in_dir, setup);
  endtask

  task automatic t_reset;
    tok_req = 1'b1;
    #1;
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 bank", bank_sel, 16'h0);
    chk("R1 stat", {stat_in, stat_odd, tsusp, resume}, 4'b0);
    chk("R4 ack disabled", tok_ack, 1'b0);
  endtask

  task automatic t_disabled;
    xact(4'd5, 1'b1, 1'b1);
    chk("R11 bank", bank_sel, 16'h0);
    chk("R11 stat", {stat_in, stat_odd}, 2'b00);
    chk("R11 lock", tsusp, 1'b0);
  endtask

  task automatic t_ctl_layout;
    wr(8'h01);
    chk("R2 enable", reg_rdata, 8'h01);
    chk("R4 ack enabled", tok_ack, 1'b1);
    wr(8'hFF);
    chk("R2 layout", reg_rdata, 8'h05);
    chk("R12 resume on", resume, 1'b1);
    chk("R5 no sw set", tsusp, 1'b0);
    wr(8'h01);
    chk("R12 resume off", resume, 1'b0);
  endtask

  task automatic t_toggle;
    xact(4'd5, 1'b0, 1'b0);
    chk("R8 ep5 odd", bank_sel, 16'h0020);
    chk("R6 out", stat_in, 1'b0);
    chk("R7 even used", stat_odd, 1'b0);
    xact(4'd5, 1'b1, 1'b0);
    chk("R8 ep5 even", bank_sel, 16'h0000);
    chk("R6 in", stat_in, 1'b1);
    chk("R7 odd used", stat_odd, 1'b1);
    xact(4'd6, 1'b1, 1'b0);
    chk("R8 ep6 odd", bank_sel, 16'h0040);
    xact(4'd3, 1'b0, 1'b0);
    chk("R8 ep3 fixed", bank_sel, 16'h0040);
    chk("R7 ep3 even", stat_odd, 1'b0);
    chk("R6 ep3 out", stat_in, 1'b0);
  endtask

  task automatic t_oddrst;
    xact(4'd5, 1'b0, 1'b0);
    chk("R9 setup", bank_sel, 16'h0060);
    wr(8'h03);
    chk("R9 cleared", bank_sel, 16'h0000);
    chk("R2 oddrst reads 0", reg_rdata, 8'h01);
    xact(4'd5, 1'b0, 1'b0);
    cycle(1'b1, 8'h03, 1'b1, 4'd5, 1'b1, 1'b0);
    chk("R9 priority", bank_sel, 16'h0000);
  endtask

  task automatic t_enable_edge;
    xact(4'd6, 1'b0, 1'b0);
    wr(8'h00);
    chk("R10 disable keeps", bank_sel, 16'h0040);
    wr(8'h01);
    chk("R10 rise clears", bank_sel, 16'h0000);
    xact(4'd5, 1'b0, 1'b0);
    wr(8'h01);
    chk("R10 rewrite keeps", bank_sel, 16'h0020);
  endtask

  task automatic t_suspend;
    chk("R4 ack open", tok_ack, 1'b1);
    xact(4'd0, 1'b0, 1'b1);
    chk("R3 lock set", tsusp, 1'b1);
    chk("R3 readback", reg_rdata, 8'h21);
    chk("R4 ack held", tok_ack, 1'b0);
    wr(8'h21);
    chk("R5 write 1 keeps", tsusp, 1'b1);
    xact(4'd0, 1'b1, 1'b1);
    chk("R3 relock", tsusp, 1'b1);
    chk("R6 setup recorded", stat_in, 1'b1);
    cycle(1'b1, 8'h01, 1'b1, 4'd0, 1'b0, 1'b1);
    chk("R5 setup wins", tsusp, 1'b1);
    wr(8'h01);
    chk("R5 cleared", tsusp, 1'b0);
    chk("R4 ack resumed", tok_ack, 1'b1);
  endtask

  task automatic t_disabled_hold;
    wr(8'h00);
    xact(4'd5, 1'b0, 1'b1);
    chk("R11 bank hold", bank_sel, 16'h0020);
    chk("R11 stat hold", {stat_in, stat_odd}, 2'b00);
    chk("R11 lock hold", tsusp, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_ctl_layout();
        t_toggle();
        t_oddrst();
        t_enable_edge();
        t_suspend();
        t_disabled_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule